// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetcher

This block watches the line addresses of cache misses and detects runs of adjacent lines, either ascending or descending. When a run is detected, it issues a burst of prefetch line addresses that continue the run in the same direction. It can track several such streams at once. Each stream slot holds a direction and the line address the stream is expected to miss on next. A later miss on that expected line starts the next burst and moves the slot forward.

Misses arrive on a valid/ready input. A miss is taken on a clock edge where `miss_valid` and `miss_ready` are both high. `miss_ready` is low while a burst is still being emitted, so the source must hold the miss steady until it is taken. Prefetch lines leave on a valid/ready output. While `pf_valid` is high and `pf_ready` is low, the block holds `pf_line` unchanged. A burst starts on the clock edge after the miss that triggers it is taken.

Misses that do not belong to a stream go into a short history. A new run is found by looking for the two previous lines of that run in this history.

Top module: `seq_line_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is low, `miss_ready` is high, no stream slot is active and the miss history is empty.
- R2: Ascending detection. A miss on line m that matches no stream, taken while both m-1 and m-2 are in the history, opens a stream. It then emits the NumPref lines m+1, m+2, … m+NumPref in that order.
- R3: Descending detection. The same rule with m+1 and m+2 in the history opens a descending stream and emits m-1 … m-NumPref. When both the ascending and the descending pattern are present, the ascending one is taken.
- R4: A miss that matches no stream and completes neither pattern produces no prefetch. Other strides, such as two lines, are never recognised.
- R5: Each burst, whether from a detection or a stream hit, sets the slot's expected line to miss ± (NumPref+1). A later miss equal to that line emits the next NumPref lines beyond it and advances the slot again.
- R6: A miss that hits a stream slot is not written into the history, so it cannot help start a new stream.
- R7: While `pf_valid` is high and `pf_ready` is low, `pf_line` holds. `miss_ready` stays low until the last line of the burst has been accepted.
- R8: Up to NumSeq streams are tracked at once. When all slots are active, a new stream replaces the least recently opened or hit slot, and the evicted stream's expected line no longer triggers prefetches.
- R9: The history keeps the last HistDepth (default 8) non-stream misses. A line pushed out of the history no longer counts toward detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss line address offered |
| miss_ready | output | 1 | Block can take a miss (no burst in progress) |
| miss_line | input | AddrW | Line address of the miss |
| pf_valid | output | 1 | Prefetch line address offered |
| pf_ready | input | 1 | Consumer takes the prefetch line |
| pf_line | output | AddrW | Line address to prefetch |

## Verification
The hardest case to reach is replacement. All NumSeq slots must be active, one of them must be refreshed by a hit, and then one more stream must be opened. Only then does it show whether the least recently used slot was the one dropped. The stimulus opens four streams in separate address regions, hits the oldest one, opens a fifth, and then misses on the expected lines of the evicted stream and of a surviving stream. History aging is reached the same way: two lines of a run are separated from the third by exactly seven or exactly six unrelated misses. Prefetch back-pressure is applied throughout.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/pfs_history.sv
module pfs_history #(
  parameter int AddrW = 32,
  parameter int Depth = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [AddrW-1:0] push_line,
  input  logic [AddrW-1:0] probe_line,
  output logic             up_ok,
  output logic             down_ok
);
  logic [AddrW-1:0] line_q [Depth];
  logic [Depth-1:0] vld_q;
  logic [Depth-1:0] has_m1, has_m2, has_p1, has_p2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < Depth; i++) line_q[i] <= '0;
    end else if (push) begin
      line_q[0] <= push_line;
      vld_q[0]  <= 1'b1;
      for (int i = 1; i < Depth; i++) begin
        line_q[i] <= line_q[i-1];
        vld_q[i]  <= vld_q[i-1];
      end
    end
  end

  for (genvar g = 0; g < Depth; g++) begin : g_cmp
    assign has_m1[g] = vld_q[g] && (line_q[g] == probe_line - AddrW'(1));
    assign has_m2[g] = vld_q[g] && (line_q[g] == probe_line - AddrW'(2));
    assign has_p1[g] = vld_q[g] && (line_q[g] == probe_line + AddrW'(1));
    assign has_p2[g] = vld_q[g] && (line_q[g] == probe_line + AddrW'(2));
  end

  assign up_ok   = (|has_m1) && (|has_m2);
  assign down_ok = (|has_p1) && (|has_p2);

  // R9: newest slot always holds the line just pushed
  p_push_newest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> vld_q[0] && line_q[0] == $past(push_line));
  // R1: history is empty right after reset
  p_empty_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> vld_q == '0);
endmodule

// File: rtl/pfs_table.sv
module pfs_table #(
  parameter int AddrW = 32,
  parameter int NumSeq = 4,
  localparam int IdxW = (NumSeq > 1) ? $clog2(NumSeq) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AddrW-1:0]  probe_line,
  output logic              hit,
  output logic [IdxW-1:0]   hit_idx,
  output pfs_pkg::dir_e     hit_dir,
  output logic [IdxW-1:0]   victim_idx,
  input  logic              wr_en,
  input  logic [IdxW-1:0]   wr_idx,
  input  pfs_pkg::dir_e     wr_dir,
  input  logic [AddrW-1:0]  wr_next
);
  logic [NumSeq-1:0] vld_q;
  pfs_pkg::dir_e     dir_q  [NumSeq];
  logic [AddrW-1:0]  next_q [NumSeq];
  logic [IdxW-1:0]   age_q  [NumSeq];

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    hit_dir = pfs_pkg::DIR_UP;
    for (int i = NumSeq - 1; i >= 0; i--) begin
      if (vld_q[i] && next_q[i] == probe_line) begin
        hit = 1'b1;
        hit_idx = IdxW'(i);
        hit_dir = dir_q[i];
      end
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < NumSeq; i++) begin
      if (!found && !vld_q[i]) begin
        found = 1'b1;
        victim_idx = IdxW'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < NumSeq; i++)
        if (age_q[i] == IdxW'(NumSeq - 1)) victim_idx = IdxW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NumSeq; i++) begin
        dir_q[i]  <= pfs_pkg::DIR_UP;
        next_q[i] <= '0;
        age_q[i]  <= IdxW'(i);
      end
    end else if (wr_en) begin
      vld_q[wr_idx]  <= 1'b1;
      dir_q[wr_idx]  <= wr_dir;
      next_q[wr_idx] <= wr_next;
      for (int i = 0; i < NumSeq; i++) begin
        if (IdxW'(i) == wr_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[wr_idx]) age_q[i] <= age_q[i] + IdxW'(1);
      end
    end
  end

  // R8: recency ranks stay a permutation of 0..NumSeq-1
  for (genvar k = 0; k < NumSeq; k++) begin : g_rank
    logic [NumSeq-1:0] has_rank;
    for (genvar j = 0; j < NumSeq; j++) begin : g_eq
      assign has_rank[j] = (age_q[j] == IdxW'(k));
    end
    p_rank_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(has_rank) == 1);
  end

  // R5, R8: a written slot becomes active, most recent, and expects the given line
  p_slot_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && age_q[$past(wr_idx)] == '0
              && next_q[$past(wr_idx)] == $past(wr_next));
endmodule

// File: rtl/pfs_burst.sv
module pfs_burst #(
  parameter int AddrW = 32,
  parameter int NumPref = 6,
  localparam int CntW = $clog2(NumPref + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AddrW-1:0] load_line,
  input  pfs_pkg::dir_e    load_dir,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [AddrW-1:0] pf_line,
  output logic             busy
);
  logic [CntW-1:0]  left_q;
  logic [AddrW-1:0] cur_q;
  pfs_pkg::dir_e    dir_q;
  logic [AddrW-1:0] step;

  assign step     = (dir_q == pfs_pkg::DIR_DOWN) ? '1 : AddrW'(1);
  assign pf_valid = (left_q != '0);
  assign busy     = pf_valid;
  assign pf_line  = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      cur_q  <= '0;
      dir_q  <= pfs_pkg::DIR_UP;
    end else if (load) begin
      left_q <= CntW'(NumPref);
      cur_q  <= load_line;
      dir_q  <= load_dir;
    end else if (pf_valid && pf_ready) begin
      left_q <= left_q - CntW'(1);
      cur_q  <= cur_q + step;
    end
  end

  // R7: a stalled prefetch holds its line
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));
  // R2: consecutive beats of one burst are one line apart
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && left_q > CntW'(1) |=>
      pf_valid && (pf_line == $past(pf_line) + $past(step)));
  // R7: a new burst is never loaded over one in progress
  p_no_reload_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && busy));
endmodule

// File: rtl/seq_line_prefetcher.sv
module seq_line_prefetcher #(
  parameter int AddrW = 32,
  parameter int NumSeq = 4,
  parameter int NumPref = 6,
  parameter int HistDepth = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [AddrW-1:0] miss_line,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [AddrW-1:0] pf_line
);
  localparam int IdxW = (NumSeq > 1) ? $clog2(NumSeq) : 1;
  localparam logic [AddrW-1:0] Span = AddrW'(NumPref + 1);

  logic            busy, fire, launch;
  logic            hit, up_ok, down_ok;
  logic [IdxW-1:0] hit_idx, victim_idx, wr_idx;
  pfs_pkg::dir_e   hit_dir, go_dir;
  logic [AddrW-1:0] next_exp, first_line;

  assign miss_ready = !busy;
  assign fire       = miss_valid && miss_ready;
  assign launch     = fire && (hit || up_ok || down_ok);
  assign go_dir     = hit ? hit_dir : (up_ok ? pfs_pkg::DIR_UP : pfs_pkg::DIR_DOWN);
  assign wr_idx     = hit ? hit_idx : victim_idx;
  assign next_exp   = (go_dir == pfs_pkg::DIR_DOWN) ? miss_line - Span : miss_line + Span;
  assign first_line = (go_dir == pfs_pkg::DIR_DOWN) ? miss_line - AddrW'(1)
                                                    : miss_line + AddrW'(1);

  pfs_history #(.AddrW(AddrW), .Depth(HistDepth)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .push(fire && !hit), .push_line(miss_line),
    .probe_line(miss_line), .up_ok(up_ok), .down_ok(down_ok)
  );

  pfs_table #(.AddrW(AddrW), .NumSeq(NumSeq)) u_tab (
    .clk(clk), .rst_n(rst_n), .probe_line(miss_line),
    .hit(hit), .hit_idx(hit_idx), .hit_dir(hit_dir), .victim_idx(victim_idx),
    .wr_en(launch), .wr_idx(wr_idx), .wr_dir(go_dir), .wr_next(next_exp)
  );

  pfs_burst #(.AddrW(AddrW), .NumPref(NumPref)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_line(first_line),
    .load_dir(go_dir), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_line(pf_line), .busy(busy)
  );

  // R2: ascending detection starts at the next line up
  p_up_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !hit && up_ok |=> pf_valid && pf_line == $past(miss_line) + AddrW'(1));
  // R3: descending detection (no ascending pattern) starts one line down
  p_down_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !hit && !up_ok && down_ok |=>
      pf_valid && pf_line == $past(miss_line) - AddrW'(1));
  // R4: an unrelated miss leaves the prefetch port idle
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !hit && !up_ok && !down_ok |=> !pf_valid);
  // R5: a stream hit always yields a burst
  p_hit_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && hit |=> pf_valid);
  // R1: idle outputs after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !pf_valid && miss_ready);
endmodule

// File: tb/sim_seq_line_prefetcher.sv
module sim_seq_line_prefetcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic miss_ready;
  logic [31:0] miss_line = '0;
  logic pf_valid;
  logic pf_ready = 1'b1;
  logic [31:0] pf_line;

  always #4 clk = ~clk;

  seq_line_prefetcher u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line(miss_line), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_extra = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit bp_on = 1'b0;
  bit was_stall = 1'b0;
  logic [31:0] stall_line;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_burst(input logic [31:0] miss, input bit down, input string tag);
    for (int k = 1; k <= 6; k++) begin
      exp_q.push_back(down ? miss - 32'(k) : miss + 32'(k));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send_miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_line = a;
    while (!miss_ready) @(negedge clk);
    @(posedge clk);
    #1 miss_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while ((exp_q.size() != 0 || pf_valid) && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {tag, " missing lines"}, 32'(exp_q.size()), 0);
    check(n_extra == 0, {tag, " unexpected lines"}, 32'(n_extra), 0);
    exp_q.delete();
    tag_q.delete();
    n_extra = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // back-pressure pattern driven just after each edge
  always @(posedge clk) begin
    cyc++;
    #1 pf_ready = bp_on ? ((cyc % 5) != 1 && (cyc % 7) != 3) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stall) // R7
        check(pf_valid && pf_line == stall_line, "R7 hold under stall", pf_line, stall_line);
      if (pf_valid)  // R7
        check(!miss_ready, "R7 miss_ready low in burst", 32'(miss_ready), 0);
      if (pf_valid && pf_ready) begin
        if (exp_q.size() == 0) begin
          n_extra++;
          $display("FAIL unexpected prefetch actual=%h expected=none", pf_line);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(pf_line == e, t, pf_line, e);
        end
      end
      was_stall = pf_valid && !pf_ready;
      stall_line = pf_line;
    end else begin
      was_stall = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(!pf_valid, "R1 pf_valid after reset", 32'(pf_valid), 0);
    check(miss_ready, "R1 miss_ready after reset", 32'(miss_ready), 1);
    // R1: empty history - two unrelated-to-anything misses give nothing
    send_miss(32'h40); send_miss(32'h41);
    drain("R1 empty history");

    // R2 ascending with back-pressure, then R5 hit chain
    bp_on = 1'b1;
    do_reset();
    send_miss(32'h100); send_miss(32'h101);
    expect_burst(32'h102, 1'b0, "R2 ascending burst");
    send_miss(32'h102);
    drain("R2");
    expect_burst(32'h109, 1'b0, "R5 first hit");
    send_miss(32'h109);
    drain("R5 first hit");
    expect_burst(32'h110, 1'b0, "R5 second hit");
    send_miss(32'h110);
    drain("R5 second hit");
    // R5: the old expected line no longer triggers
    send_miss(32'h109);
    drain("R5 stale expected");
    // R6: hit misses 0x110 not in history, so 0x111,0x112 do not open a stream
    send_miss(32'h111); send_miss(32'h112);
    drain("R6 hit not in history");

    // R3 descending, and ascending priority
    do_reset();
    send_miss(32'h600); send_miss(32'h5FF);
    expect_burst(32'h5FE, 1'b1, "R3 descending burst");
    send_miss(32'h5FE);
    drain("R3 descending");
    expect_burst(32'h5F7, 1'b1, "R5 descending hit");
    send_miss(32'h5F7);
    drain("R5 descending hit");
    do_reset();
    send_miss(32'h6FE); send_miss(32'h6FF); send_miss(32'h702); send_miss(32'h701);
    drain("R3 no early stream");
    expect_burst(32'h700, 1'b0, "R3 ascending wins");
    send_miss(32'h700);
    drain("R3 priority");

    // R4 stride two and scattered lines
    do_reset();
    send_miss(32'h800); send_miss(32'h802); send_miss(32'h804);
    send_miss(32'h900); send_miss(32'h880); send_miss(32'h901);
    drain("R4 no stream");

    // R8 LRU replacement
    bp_on = 1'b0;
    do_reset();
    for (int s = 1; s <= 4; s++) begin
      logic [31:0] b;
      b = 32'(s) << 8;
      send_miss(b); send_miss(b + 1);
      expect_burst(b + 2, 1'b0, "R8 open stream");
      send_miss(b + 2);
      drain("R8 open");
    end
    expect_burst(32'h109, 1'b0, "R8 refresh oldest");
    send_miss(32'h109);
    drain("R8 refresh");
    send_miss(32'h500); send_miss(32'h501);
    expect_burst(32'h502, 1'b0, "R8 fifth stream");
    send_miss(32'h502);
    drain("R8 fifth");
    send_miss(32'h209);
    drain("R8 evicted stream silent");
    expect_burst(32'h309, 1'b0, "R8 survivor hit");
    send_miss(32'h309);
    drain("R8 survivor");
    expect_burst(32'h110, 1'b0, "R8 refreshed survives");
    send_miss(32'h110);
    drain("R8 refreshed");

    // R9 history depth
    bp_on = 1'b1;
    do_reset();
    send_miss(32'hA00); send_miss(32'hA01);
    for (int k = 0; k < 6; k++) send_miss(32'h2000 + 32'(k) * 32'h10);
    expect_burst(32'hA02, 1'b0, "R9 still in history");
    send_miss(32'hA02);
    drain("R9 depth edge");
    do_reset();
    send_miss(32'hB00); send_miss(32'hB01);
    for (int k = 0; k < 7; k++) send_miss(32'h3000 + 32'(k) * 32'h10);
    send_miss(32'hB02);
    drain("R9 aged out");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule